// File: doc/BRIEF.md
# Reset Cause and Low-Power Entry Control Registers

This block sits on a 16-bit peripheral register bus. It holds two registers that a system-integration unit needs. The control register lets software request a device reset. It also decides whether the core's STOP and WAIT instructions are allowed to put the device into their low-power modes. Each of the two low-power disable fields can be left writable or frozen until the next device reset. A frozen field cannot be reopened by errant code.

The status register keeps one sticky flag for each reset cause: power-on, external pin, watchdog and software. Any reset other than power-on only adds its own flag, so software can tell what happened across a chain of resets. Software clears a flag by writing 1 to it. The reset controller reports each applied reset through one level input per cause, held high while that reset is applied. Power-on is the asynchronous `por_n` input.

Top module: `rst_lp_ctrl_regs`

## Requirements
- R1: After power-on reset, the control register (offset 0, `bus_addr_i`=0) reads 0x0000 and the status register (offset 1) reads 0x0004 (only the power-on flag, bit 2, is set).
- R2: A write to the control register with bit 4 set drives `sw_rst_req_o` high for exactly the one cycle after the write edge. Bit 4 always reads as 0.
- R3: The STOP field is control bits 3:2. With value 00, `stop_enter_o` follows `stop_req_i`. With any other value, `stop_enter_o` is 0.
- R4: If the STOP field holds 00 or 01, a write replaces it. Once it holds 10 or 11, writes leave it unchanged until a device reset. The lock does not affect the WAIT field in the same write.
- R5: The WAIT field is control bits 1:0. It has the same allow, block and lock behaviour as the STOP field, and gates `wait_req_i` onto `wait_enter_o`.
- R6: Control bits 15:5 and status bits 15:6 and 1:0 read as 0, and writes to them have no effect.
- R7: Holding `sw_rst_i`, `ext_rst_i` or `wdog_rst_i` high for a cycle sets status bit 5, 3 or 4 respectively. It leaves flags that are already set unchanged, and returns the control register to 0, unlocking both fields. Bus writes in that cycle are ignored.
- R8: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: If a clearing write and a reset event hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_i | input | 1 | External reset applied this cycle |
| wdog_rst_i | input | 1 | Watchdog reset applied this cycle |
| sw_rst_i | input | 1 | Software reset applied this cycle |
| stop_req_i | input | 1 | Core executes STOP |
| wait_req_i | input | 1 | Core executes WAIT |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 1 | Register offset: 0 control, 1 status |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| sw_rst_req_o | output | 1 | One-cycle software reset request |
| stop_enter_o | output | 1 | Qualified Stop mode entry |
| wait_enter_o | output | 1 | Qualified Wait mode entry |

## Verification
The bench tries to rewrite a locked field to both 00 and 11, and pairs that write with a change to the other field. A design that checked the wrong bit for the lock, or locked the whole register, would show a moved or a frozen field. It applies the external, watchdog and software resets in turn and expects earlier flags to survive. A design that re-initialised on every reset would lose them. It also clears a flag in the same cycle its cause fires, where clear-wins logic would drop the flag. Writes of 1 to reserved status bits must not disturb the real flags.

// File: rtl/rst_lp_ctrl_regs.sv
module rst_lp_ctrl_regs (
  input  logic        clk,
  input  logic        por_n,
  input  logic        ext_rst_i,
  input  logic        wdog_rst_i,
  input  logic        sw_rst_i,
  input  logic        stop_req_i,
  input  logic        wait_req_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic        bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        sw_rst_req_o,
  output logic        stop_enter_o,
  output logic        wait_enter_o
);

  logic [1:0] stop_dis;
  logic [1:0] wait_dis;
  logic [3:0] flags;
  logic       any_rst;
  logic       wr_ctrl;
  logic       wr_stat;
  logic [3:0] clr_mask;
  logic [3:0] set_mask;
  logic       unused_wdata;

  assign any_rst  = ext_rst_i | wdog_rst_i | sw_rst_i;
  assign wr_ctrl  = bus_sel_i & bus_wr_i & ~bus_addr_i & ~any_rst;
  assign wr_stat  = bus_sel_i & bus_wr_i &  bus_addr_i;
  assign clr_mask = wr_stat ? bus_wdata_i[5:2] : 4'b0000;
  assign set_mask = {sw_rst_i, wdog_rst_i, ext_rst_i, 1'b0};
  assign unused_wdata = &{1'b0, bus_wdata_i[15:6]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stop_dis <= 2'b00;
      wait_dis <= 2'b00;
    end else if (any_rst) begin
      stop_dis <= 2'b00;
      wait_dis <= 2'b00;
    end else if (wr_ctrl) begin
      if (!stop_dis[1]) stop_dis <= bus_wdata_i[3:2];
      if (!wait_dis[1]) wait_dis <= bus_wdata_i[1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sw_rst_req_o <= 1'b0;
    else        sw_rst_req_o <= wr_ctrl & bus_wdata_i[4];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flags <= 4'b0001;
    else        flags <= (flags & ~clr_mask) | set_mask;
  end

  assign bus_rdata_o  = bus_addr_i ? {10'b0, flags, 2'b00} : {12'b0, stop_dis, wait_dis};
  assign stop_enter_o = stop_req_i & (stop_dis == 2'b00);
  assign wait_enter_o = wait_req_i & (wait_dis == 2'b00);

  a_r2_pulse_source: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sw_rst_req_o) |-> $past(bus_sel_i && bus_wr_i && !bus_addr_i && bus_wdata_i[4]));

  a_r4_stop_locked: assert property (@(posedge clk) disable iff (!por_n)
    (stop_dis[1] && !any_rst) |=> $stable(stop_dis));

  a_r5_wait_locked: assert property (@(posedge clk) disable iff (!por_n)
    (wait_dis[1] && !any_rst) |=> $stable(wait_dis));

  a_r7_ctrl_cleared: assert property (@(posedge clk) disable iff (!por_n)
    any_rst |=> (stop_dis == 2'b00 && wait_dis == 2'b00));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !wr_stat |=> ((flags & $past(flags)) == $past(flags)));

  a_r9_ext_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst_i |=> flags[1]);

  a_r9_wdog_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    wdog_rst_i |=> flags[2]);

  a_r9_sw_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst_i |=> flags[3]);

endmodule

// File: tb/rst_lp_ctrl_regs_tb.sv
module rst_lp_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ext_rst_i = 1'b0, wdog_rst_i = 1'b0, sw_rst_i = 1'b0;
  logic        stop_req_i = 1'b0, wait_req_i = 1'b0;
  logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0, bus_addr_i = 1'b0;
  logic [15:0] bus_wdata_i = 16'h0;
  logic [15:0] bus_rdata_o;
  logic        sw_rst_req_o, stop_enter_o, wait_enter_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_lp_ctrl_regs u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_i(ext_rst_i), .wdog_rst_i(wdog_rst_i),
    .sw_rst_i(sw_rst_i), .stop_req_i(stop_req_i), .wait_req_i(wait_req_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .sw_rst_req_o(sw_rst_req_o), .stop_enter_o(stop_enter_o),
    .wait_enter_o(wait_enter_o));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = 16'h0;
  endtask

  task automatic read_chk(input string req, input logic a, input logic [15:0] exp);
    bus_addr_i = a;
    #1;
    check(req, bus_rdata_o, exp);
  endtask

  task automatic gates_chk(input string req, input logic s_exp, input logic w_exp);
    stop_req_i = 1'b1; wait_req_i = 1'b1;
    #1;
    check({req, " stop"}, {15'b0, stop_enter_o}, {15'b0, s_exp});
    check({req, " wait"}, {15'b0, wait_enter_o}, {15'b0, w_exp});
    stop_req_i = 1'b0; wait_req_i = 1'b0;
  endtask

  task automatic t_reset;
    read_chk("R1 ctrl after por", 1'b0, 16'h0000);
    read_chk("R1 status after por", 1'b1, 16'h0004);
    gates_chk("R3 R5 allowed after por", 1'b1, 1'b1);
  endtask

  task automatic t_sw_reset;
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 1'b0; bus_wdata_i = 16'h0010;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = 16'h0;
    check("R2 request high", {15'b0, sw_rst_req_o}, 16'h0001);
    read_chk("R2 bit4 reads 0", 1'b0, 16'h0000);
    @(negedge clk);
    check("R2 request one cycle", {15'b0, sw_rst_req_o}, 16'h0000);
    @(negedge clk); sw_rst_i = 1'b1;
    @(negedge clk); sw_rst_i = 1'b0;
    read_chk("R7 sw flag set, por kept", 1'b1, 16'h0024);
  endtask

  task automatic t_stop;
    bus_write(1'b0, 16'h0004);
    read_chk("R4 stop 01 written", 1'b0, 16'h0004);
    gates_chk("R3 stop 01 blocks", 1'b0, 1'b1);
    bus_write(1'b0, 16'h0000);
    read_chk("R4 stop 01 still writable", 1'b0, 16'h0000);
    gates_chk("R3 stop 00 allows", 1'b1, 1'b1);
    bus_write(1'b0, 16'h0008);
    bus_write(1'b0, 16'h0000);
    read_chk("R4 stop 10 locked vs 00", 1'b0, 16'h0008);
    bus_write(1'b0, 16'h000D);
    read_chk("R4 stop locked, wait still written", 1'b0, 16'h0009);
    gates_chk("R3 R5 stop 10 wait 01 block", 1'b0, 1'b0);
  endtask

  task automatic t_ext_reset;
    @(negedge clk); ext_rst_i = 1'b1;
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 1'b0; bus_wdata_i = 16'h0005;
    @(negedge clk); ext_rst_i = 1'b0;
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = 16'h0;
    read_chk("R7 ext reset clears ctrl, write ignored", 1'b0, 16'h0000);
    read_chk("R7 ext flag set, others kept", 1'b1, 16'h002C);
    gates_chk("R7 unlocked and allowed", 1'b1, 1'b1);
  endtask

  task automatic t_wait;
    bus_write(1'b0, 16'h0003);
    gates_chk("R5 wait 11 blocks", 1'b1, 1'b0);
    bus_write(1'b0, 16'h0000);
    read_chk("R5 wait 11 locked", 1'b0, 16'h0003);
    bus_write(1'b0, 16'h0004);
    read_chk("R5 wait locked, stop still written", 1'b0, 16'h0007);
    bus_write(1'b0, 16'h0000);
    read_chk("R5 stop 01 reopened, wait locked", 1'b0, 16'h0003);
    @(negedge clk); wdog_rst_i = 1'b1;
    @(negedge clk); wdog_rst_i = 1'b0;
    read_chk("R7 watchdog reset clears ctrl", 1'b0, 16'h0000);
    read_chk("R7 watchdog flag set", 1'b1, 16'h003C);
  endtask

  task automatic t_reserved;
    bus_write(1'b0, 16'hFFE0);
    read_chk("R6 ctrl reserved bits", 1'b0, 16'h0000);
    check("R6 no reset request", {15'b0, sw_rst_req_o}, 16'h0000);
    bus_write(1'b1, 16'hFFC3);
    read_chk("R6 status reserved bits", 1'b1, 16'h003C);
  endtask

  task automatic t_clear;
    bus_write(1'b1, 16'h0020);
    read_chk("R8 clear sw flag", 1'b1, 16'h001C);
    bus_write(1'b1, 16'h0000);
    read_chk("R8 write 0 no effect", 1'b1, 16'h001C);
    bus_write(1'b1, 16'h0014);
    read_chk("R8 clear wdog and por", 1'b1, 16'h0008);
  endtask

  task automatic t_set_wins;
    @(negedge clk); wdog_rst_i = 1'b1;
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 1'b1; bus_wdata_i = 16'h0018;
    @(negedge clk); wdog_rst_i = 1'b0;
    bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = 16'h0;
    read_chk("R9 set wins, other cleared", 1'b1, 16'h0010);
    bus_write(1'b1, 16'h003C);
    read_chk("R8 all cleared", 1'b1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_reset();
    t_stop();
    t_ext_reset();
    t_wait();
    t_reserved();
    t_clear();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule